// File: doc/BRIEF.md
# Embedded-Sync 16-bit Interlaced Video Output Generator

This block turns a stream of 16-bit pixel words into a 16-bit parallel interlaced video signal in which all line and field timing travels inside the data. There are no separate sync pins. Each line starts with an end-of-active-video timing code. Blanking words follow, then a start-of-active-video timing code, then the active words. The active words are pulled from a ready/valid pixel source.

A horizontal word counter and a frame line counter place every word. The line length, the blanking length, the frame length, the start of the second field and the two active-line windows all come from configuration inputs. These inputs are captured only at a frame boundary, so standard-definition and high-definition timings can both be selected at run time. The blanking counter is as wide as the line counter, so HD blanking lengths of 280 and 720 words are held exactly.

Top module: `vsg_bt1120_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to word 0 of line 0. After that edge `vid_data` is 16'h1080, `underrun` is 0 and `pix_ready` is 0.
- R2: Words 0 to 3 of every line form the end-of-active-video code. The upper byte carries FF, 00, 00, then XY with H=1. The lower byte is 00.
- R3: Words `hblank-4` to `hblank-1` form the start-of-active-video code. The upper byte carries FF, 00, 00, then XY with H=0. The lower byte is 00.
- R4: The XY byte is {1, F, V, H, V^H, F^H, F^V, F^V^H}, from bit 7 down to bit 0. The eight combinations give 80, 9D, AB, B6, C7, DA, EC and F1 for FVH = 000 through 111.
- R5: Each word between the two codes is 16'h1080. Each word after the start code on a vertical-blanking line is also 16'h1080.
- R6: On an active line, words `hblank` to `line_words-1` are active. `pix_ready` is high for exactly those words. A word accepted with `pix_valid` high appears on `vid_data` one clock later.
- R7: If `pix_valid` is low during an active word, the block outputs 16'h1080 and raises `underrun` for that output word. Line timing does not move.
- R8: The blanking length is held to the full counter width. With 2200/280 the line has 1920 active words, and with 2640/720 it also has 1920.
- R9: F is 1 on lines at or after `cfg_field2_line`. V is 0 only on lines inside [act1_first, act1_end) or [act2_first, act2_end). F and V change only at word 0 of a line.
- R10: A change on the configuration inputs takes effect at the first word of the next frame and never mid-frame.
- R11: The word counter wraps after `line_words` words. The line counter wraps after `frame_lines` lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_line_words | input | H_W | Total words per line |
| cfg_hblank_words | input | H_W | Words from the first code word to the last start-code word, inclusive |
| cfg_frame_lines | input | V_W | Lines per frame |
| cfg_field2_line | input | V_W | First line of the second field |
| cfg_act1_first | input | V_W | First active line of field 1 |
| cfg_act1_end | input | V_W | Line after the last active line of field 1 |
| cfg_act2_first | input | V_W | First active line of field 2 |
| cfg_act2_end | input | V_W | Line after the last active line of field 2 |
| pix_valid | input | 1 | Pixel word available |
| pix_data | input | 16 | Pixel word |
| pix_ready | output | 1 | Block takes a pixel word this cycle |
| vid_data | output | 16 | Video output word |
| underrun | output | 1 | Current output word replaced a missing pixel |

## Verification
The bench targets the blanking lengths above 255 words. A counter truncated to 8 bits would leave 2176 or 2432 active words per line instead of 1920. It changes the configuration in the middle of a frame, where a design that applies the change early would shorten or lengthen a line before the frame ends. Every one of the eight XY values is compared against a literal table, which exposes a wrong protection bit or a swapped flag. A random pattern of gaps in `pix_valid` checks that a missing pixel becomes blanking with `underrun` set and never delays the next timing code.

// File: rtl/vsg_pkg.sv
// Shared types and helpers for the embedded-sync video generator.
// Assumes a 16-bit output word with timing codes on the upper byte.
package vsg_pkg;

    localparam logic [15:0] BLANK_WORD = 16'h1080;
    localparam int          CODE_WORDS = 4;

    typedef enum logic [1:0] {
        SEG_EAV  = 2'd0,
        SEG_HBLK = 2'd1,
        SEG_SAV  = 2'd2,
        SEG_ACT  = 2'd3
    } seg_t;

    // Build the fourth timing-code byte with its protection bits.
    function automatic logic [7:0] trs_xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/vsg_timing.sv
// Horizontal word counter, frame line counter and per-frame configuration shadow.
// Assumes line_words > hblank >= 8 and frame_lines >= 1. Segment and F/V
// flags are decoded from the counters for the current word.
module vsg_timing
    import vsg_pkg::*;
#(
    parameter int H_W = 12,
    parameter int V_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [H_W-1:0] cfg_line_words,
    input  logic [H_W-1:0] cfg_hblank_words,
    input  logic [V_W-1:0] cfg_frame_lines,
    input  logic [V_W-1:0] cfg_field2_line,
    input  logic [V_W-1:0] cfg_act1_first,
    input  logic [V_W-1:0] cfg_act1_end,
    input  logic [V_W-1:0] cfg_act2_first,
    input  logic [V_W-1:0] cfg_act2_end,
    output seg_t           seg,
    output logic [1:0]     sub,
    output logic           f_bit,
    output logic           v_bit
);

    localparam logic [H_W-1:0] CODE_LEN = H_W'(CODE_WORDS);
    localparam logic [H_W-1:0] H_ONE    = H_W'(1);
    localparam logic [V_W-1:0] V_ONE    = V_W'(1);

    logic [H_W-1:0] h_cnt;
    logic [V_W-1:0] ln_cnt;
    logic [H_W-1:0] lw_q, hb_q;
    logic [V_W-1:0] fl_q, f2_q, a1f_q, a1e_q, a2f_q, a2e_q;
    logic           end_line, end_frame, load_cfg;
    logic [H_W-1:0] sav_start, sav_off;

    assign end_line  = (h_cnt == lw_q - H_ONE);
    assign end_frame = end_line && (ln_cnt == fl_q - V_ONE);
    assign load_cfg  = !rst_n || end_frame;

    // Capture the configuration only at reset or at a frame boundary.
    always_ff @(posedge clk) begin
        if (load_cfg) begin
            lw_q  <= cfg_line_words;
            hb_q  <= cfg_hblank_words;
            fl_q  <= cfg_frame_lines;
            f2_q  <= cfg_field2_line;
            a1f_q <= cfg_act1_first;
            a1e_q <= cfg_act1_end;
            a2f_q <= cfg_act2_first;
            a2e_q <= cfg_act2_end;
        end
    end

    // Advance the word counter and step the line counter at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cnt  <= '0;
            ln_cnt <= '0;
        end else if (end_line) begin
            h_cnt  <= '0;
            ln_cnt <= end_frame ? '0 : ln_cnt + V_ONE;
        end else begin
            h_cnt <= h_cnt + H_ONE;
        end
    end

    assign sav_start = hb_q - CODE_LEN;
    assign sav_off   = h_cnt - sav_start;

    // Decode which part of the line the current word belongs to.
    always_comb begin
        if (h_cnt < CODE_LEN) begin
            seg = SEG_EAV;
            sub = h_cnt[1:0];
        end else if (h_cnt < sav_start) begin
            seg = SEG_HBLK;
            sub = 2'd0;
        end else if (h_cnt < hb_q) begin
            seg = SEG_SAV;
            sub = sav_off[1:0];
        end else begin
            seg = SEG_ACT;
            sub = 2'd0;
        end
    end

    // Field and vertical-blanking flags from the line number.
    always_comb begin
        f_bit = (ln_cnt >= f2_q);
        v_bit = !(((ln_cnt >= a1f_q) && (ln_cnt < a1e_q)) ||
                  ((ln_cnt >= a2f_q) && (ln_cnt < a2e_q)));
    end

    p_h_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        h_cnt < lw_q);
    p_line_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_cnt != $past(ln_cnt)) |-> (h_cnt == '0));
    p_cfg_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((lw_q != $past(lw_q)) || (hb_q != $past(hb_q))) |-> (h_cnt == '0 && ln_cnt == '0));
    p_fv_at_eav_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((f_bit != $past(f_bit)) || (v_bit != $past(v_bit))) |-> (seg == SEG_EAV && sub == 2'd0));

endmodule

// File: rtl/vsg_trs.sv
// Combinational timing-code word builder. Code bytes sit on the upper byte
// of the word and the lower byte is zero. Assumes sub counts 0..3 in a code.
module vsg_trs
    import vsg_pkg::*;
(
    input  seg_t        seg,
    input  logic [1:0]  sub,
    input  logic        f_bit,
    input  logic        v_bit,
    output logic [15:0] code_word
);

    logic [7:0] code_byte;
    logic       h_bit;

    assign h_bit = (seg == SEG_EAV);

    // Pick the code byte for the current position in the four-word code.
    always_comb begin
        case (sub)
            2'd0:    code_byte = 8'hFF;
            2'd3:    code_byte = trs_xy(f_bit, v_bit, h_bit);
            default: code_byte = 8'h00;
        endcase
    end

    assign code_word = {code_byte, 8'h00};

endmodule

// File: rtl/vsg_out.sv
// Output register, pixel handshake and underrun substitution.
// Assumes seg/v_bit describe the current word. The output lags by one clock.
module vsg_out
    import vsg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  seg_t        seg,
    input  logic [1:0]  sub,
    input  logic        v_bit,
    input  logic [15:0] code_word,
    input  logic        pix_valid,
    input  logic [15:0] pix_data,
    output logic        pix_ready,
    output logic [15:0] vid_data,
    output logic        underrun
);

    logic active_word;

    assign active_word = (seg == SEG_ACT) && !v_bit;
    assign pix_ready   = active_word;

    // Register the output word and flag any missing pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_data <= BLANK_WORD;
            underrun <= 1'b0;
        end else begin
            underrun <= active_word && !pix_valid;
            unique case (seg)
                SEG_EAV, SEG_SAV: vid_data <= code_word;
                SEG_HBLK:         vid_data <= BLANK_WORD;
                default:          vid_data <= (active_word && pix_valid) ? pix_data : BLANK_WORD;
            endcase
        end
    end

    p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready && pix_valid) |=> (vid_data == $past(pix_data) && !underrun));
    p_underrun_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (vid_data == BLANK_WORD));
    p_code_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == SEG_EAV || seg == SEG_SAV) |=> (vid_data[7:0] == 8'h00));
    p_xy_marker_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == SEG_EAV && sub == 2'd3) |=> (vid_data[15] && vid_data[12]));

endmodule

// File: rtl/vsg_bt1120_gen.sv
// Top level of the embedded-sync 16-bit interlaced video generator.
// Assumes configuration inputs are consistent; they are captured per frame.
module vsg_bt1120_gen
    import vsg_pkg::*;
#(
    parameter int H_W = 12,
    parameter int V_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [H_W-1:0] cfg_line_words,
    input  logic [H_W-1:0] cfg_hblank_words,
    input  logic [V_W-1:0] cfg_frame_lines,
    input  logic [V_W-1:0] cfg_field2_line,
    input  logic [V_W-1:0] cfg_act1_first,
    input  logic [V_W-1:0] cfg_act1_end,
    input  logic [V_W-1:0] cfg_act2_first,
    input  logic [V_W-1:0] cfg_act2_end,
    input  logic           pix_valid,
    input  logic [15:0]    pix_data,
    output logic           pix_ready,
    output logic [15:0]    vid_data,
    output logic           underrun
);

    seg_t        seg;
    logic [1:0]  sub;
    logic        f_bit, v_bit;
    logic [15:0] code_word;

    vsg_timing #(.H_W(H_W), .V_W(V_W)) u_timing (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_line_words   (cfg_line_words),
        .cfg_hblank_words (cfg_hblank_words),
        .cfg_frame_lines  (cfg_frame_lines),
        .cfg_field2_line  (cfg_field2_line),
        .cfg_act1_first   (cfg_act1_first),
        .cfg_act1_end     (cfg_act1_end),
        .cfg_act2_first   (cfg_act2_first),
        .cfg_act2_end     (cfg_act2_end),
        .seg              (seg),
        .sub              (sub),
        .f_bit            (f_bit),
        .v_bit            (v_bit)
    );

    vsg_trs u_trs (
        .seg       (seg),
        .sub       (sub),
        .f_bit     (f_bit),
        .v_bit     (v_bit),
        .code_word (code_word)
    );

    vsg_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .seg       (seg),
        .sub       (sub),
        .v_bit     (v_bit),
        .code_word (code_word),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .pix_ready (pix_ready),
        .vid_data  (vid_data),
        .underrun  (underrun)
    );

endmodule

// File: tb/sim_vsg_bt1120_gen.sv
module sim_vsg_bt1120_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] c_lw, c_hb;
    logic [10:0] c_fl, c_f2, c_a1f, c_a1e, c_a2f, c_a2e;
    logic        pix_valid = 1'b0;
    logic [15:0] pix_data = 16'h0;
    logic        pix_ready;
    logic [15:0] vid_data;
    logic        underrun;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit checking = 0;

    always #2 clk = ~clk;

    vsg_bt1120_gen u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_line_words(c_lw), .cfg_hblank_words(c_hb), .cfg_frame_lines(c_fl),
        .cfg_field2_line(c_f2), .cfg_act1_first(c_a1f), .cfg_act1_end(c_a1e),
        .cfg_act2_first(c_a2f), .cfg_act2_end(c_a2e),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_ready(pix_ready), .vid_data(vid_data), .underrun(underrun)
    );

    // Reference model state
    int mh, ml, m_lw, m_hb, m_fl, m_f2, m_a1f, m_a1e, m_a2f, m_a2e;
    logic [15:0] e_dout;
    logic        e_und;
    string       e_tag;

    // R4: literal XY table, index {F,V,H}
    function automatic logic [7:0] xy_lit(input logic [2:0] fvh);
        case (fvh)
            3'b000: return 8'h80; 3'b001: return 8'h9D;
            3'b010: return 8'hAB; 3'b011: return 8'hB6;
            3'b100: return 8'hC7; 3'b101: return 8'hDA;
            3'b110: return 8'hEC; default: return 8'hF1;
        endcase
    endfunction

    function automatic logic m_v(input int ln);
        return !((ln >= m_a1f && ln < m_a1e) || (ln >= m_a2f && ln < m_a2e));
    endfunction

    function automatic logic [7:0] code_byte(input int k, input logic [7:0] xy);
        if (k == 0) return 8'hFF;
        if (k == 3) return xy;
        return 8'h00;
    endfunction

    task automatic load_model();
        m_lw = c_lw; m_hb = c_hb; m_fl = c_fl; m_f2 = c_f2;
        m_a1f = c_a1f; m_a1e = c_a1e; m_a2f = c_a2f; m_a2e = c_a2e;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (line %0d word %0d)", tag, act, exp, ml, mh);
        end
    endtask

    task automatic set_cfg(input int lw, input int hb, input int fl, input int f2,
                           input int a1f, input int a1e, input int a2f, input int a2e);
        c_lw = 12'(lw); c_hb = 12'(hb); c_fl = 11'(fl); c_f2 = 11'(f2);
        c_a1f = 11'(a1f); c_a1e = 11'(a1e); c_a2f = 11'(a2f); c_a2e = 11'(a2e);
    endtask

    // Model: expected output for the word at the current position, then advance
    always @(posedge clk) begin
        logic f, v;
        if (!rst_n) begin
            mh = 0; ml = 0; load_model();
            e_dout = 16'h1080; e_und = 1'b0; e_tag = "R1";
        end else begin
            f = (ml >= m_f2);
            v = m_v(ml);
            e_und = 1'b0;
            if (mh < 4) begin
                e_dout = {code_byte(mh, xy_lit({f, v, 1'b1})), 8'h00};
                e_tag = (mh == 3) ? "R4/R9 eav" : "R2";
            end else if (mh < m_hb - 4) begin
                e_dout = 16'h1080; e_tag = "R5";
            end else if (mh < m_hb) begin
                e_dout = {code_byte(mh - (m_hb - 4), xy_lit({f, v, 1'b0})), 8'h00};
                e_tag = (mh == m_hb - 1) ? "R4 sav" : "R3";
            end else if (v) begin
                e_dout = 16'h1080; e_tag = "R5 vblank";
            end else if (pix_valid) begin
                e_dout = pix_data; e_tag = "R6";
            end else begin
                e_dout = 16'h1080; e_und = 1'b1; e_tag = "R7";
            end
            // R11 wrap, R10 config only at frame start
            if (mh == m_lw - 1) begin
                mh = 0;
                if (ml == m_fl - 1) begin ml = 0; load_model(); end
                else ml = ml + 1;
            end else mh = mh + 1;
        end
    end

    // Per-word comparison and HD active-word count (R8)
    int  rdy_cnt = 0;
    bit  hd_mode = 0;
    always @(negedge clk) begin
        if (checking && !done) begin
            chk(vid_data == e_dout, e_tag, vid_data, e_dout);
            chk(underrun == e_und, {e_tag, " underrun R7"}, underrun, e_und);
            chk(pix_ready == (rst_n && mh >= m_hb && !m_v(ml)), "R6 ready", pix_ready,
                rst_n && mh >= m_hb && !m_v(ml));
            if (rst_n && mh == 0) begin
                if (hd_mode && rdy_cnt > 0) chk(rdy_cnt == 1920, "R8 active words", rdy_cnt, 1920);
                rdy_cnt = 0;
            end
            if (pix_ready) rdy_cnt++;
        end
        pix_valid <= ($urandom % 4) != 0;
        pix_data  <= 16'($urandom);
    end

    initial begin
        void'($urandom(32'd4711));
        set_cfg(40, 16, 12, 6, 2, 5, 8, 11);
        repeat (3) @(posedge clk);
        checking = 1;
        @(negedge clk);
        // R1 reset state
        chk(vid_data == 16'h1080, "R1 vid_data", vid_data, 16'h1080);
        chk(underrun == 1'b0, "R1 underrun", underrun, 0);
        chk(pix_ready == 1'b0, "R1 ready", pix_ready, 0);
        rst_n = 1'b1;
        repeat (960) @(negedge clk);
        // R10: change mid-frame, must wait for frame start
        repeat (200) @(negedge clk);
        set_cfg(48, 20, 10, 5, 1, 4, 6, 9);
        repeat (1400) @(negedge clk);
        // R8: HD horizontal timing, short frame
        set_cfg(2200, 280, 4, 2, 1, 2, 3, 4);
        wait (m_lw == 2200);
        @(negedge clk);
        hd_mode = 1;
        repeat (9000) @(negedge clk);
        hd_mode = 0;
        set_cfg(2640, 720, 4, 2, 1, 2, 3, 4);
        wait (m_lw == 2640);
        @(negedge clk);
        hd_mode = 1;
        repeat (11000) @(negedge clk);
        // R1 reset mid-line
        rst_n = 1'b0;
        hd_mode = 0;
        @(negedge clk);
        chk(vid_data == 16'h1080 && !underrun && !pix_ready, "R1 reset again", vid_data, 16'h1080);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule